// File: doc/BRIEF.md
# Bus Error Status Register

This block holds the error status for the processor-bus side of a host bridge. Two single-cycle event inputs record their errors as sticky bits. One event is a pulse from an external address-bus time-out timer. The other is a data-bus parity error reported by the bridge. A third sticky bit, the overflow flag, records that a new error arrived while earlier status was still pending. Software reads the status through a small word-addressed register port and clears bits by writing ones to them.

A companion enable register decides how each error is signalled. Each error has its own machine-check enable and its own interrupt enable. Machine-checks go to a single bus master, picked by a 2-bit master-ID input that is decoded into a one-hot vector of four outputs. Interrupts go to one shared request line. Both kinds of output are levels. An output stays up until the status bit that causes it is cleared or its enable is removed.

The asynchronous active-low reset is released through a two-stage synchronizer. Nothing is signalled out of reset.

Top module: `bus_err_stat`

## Requirements
- R1: While reset is asserted, and after it is released, every status bit and every enable bit is zero. Reads at both addresses return zero, `irq_o` is 0 and `mchk_o` is 0000.
- R2: A pulse on `tmo_evt_i` sets status bit 0 (time-out) on the next clock edge. The bit then stays set until software clears it.
- R3: A pulse on `par_evt_i` sets status bit 1 (parity error) on the next clock edge. The bit then stays set until software clears it.
- R4: Status bit 7 (overflow) is set when either event arrives while any of status bits 0, 1 or 7 was already set before that cycle. If both events arrive together while all three of those bits are clear, overflow is not set.
- R5: A write to word address 0 with `wstrb_i[0]` high clears each of status bits 0, 1 and 7 whose write-data bit is 1. Write-data bits that are 0 leave the status unchanged. A write to address 0 with `wstrb_i[0]` low changes nothing.
- R6: If an event and a clear of the same status bit happen in the same cycle, the bit ends up set. Overflow in that cycle is computed from the status held before it.
- R7: Word address 1 holds the enable register, which can be read and written. A write with `wstrb_i[0]` high loads bits 3:0 from the write data. The bits are: bit 0 = time-out machine-check, bit 1 = time-out interrupt, bit 2 = parity machine-check, bit 3 = parity interrupt. The other bits read as 0.
- R8: `mchk_o` is one-hot at index `mid_i` when any status bit is set and its machine-check enable is set. Otherwise `mchk_o` is 0000. Overflow never drives it.
- R9: `irq_o` is 1 when any status bit is set and its interrupt enable is set. It drops when the bit is cleared or the enable is removed.
- R10: Status bits 6:2 and 31:8 read as 0. Any word address other than 0 and 1 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | 4 | Word address for reads and writes |
| wdata_i | input | 32 | Write data |
| wstrb_i | input | 4 | Byte-lane write strobes; any set lane is a write |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| tmo_evt_i | input | 1 | Single-cycle address-bus time-out event |
| par_evt_i | input | 1 | Single-cycle data-bus parity error event |
| mid_i | input | 2 | Master ID that receives machine-checks |
| mchk_o | output | 4 | One-hot machine-check request per master |
| irq_o | output | 1 | Interrupt request level |

## Verification
The hardest case to reach from the ports is a clear and an event on the same bit in one cycle. The set must win, and overflow must use the pre-cycle status, not the cleared value. The vector table makes this happen by driving a write-one-to-clear and a time-out pulse in the same vector, while the status is known to be non-empty. A second vector fires both events on an empty status, to show that overflow stays low.

// File: rtl/bus_err_pkg.sv
package bus_err_pkg;
  localparam int DATA_W     = 32;
  localparam int STRB_W     = DATA_W / 8;
  localparam int ADDR_W     = 4;
  localparam int N_MASTERS  = 4;
  localparam int MID_W      = $clog2(N_MASTERS);
  localparam int EN_W       = 4;

  localparam logic [ADDR_W-1:0] STAT_ADDR = 4'd0;
  localparam logic [ADDR_W-1:0] ENAB_ADDR = 4'd1;

  localparam int TMO_BIT = 0;
  localparam int PAR_BIT = 1;
  localparam int OVF_BIT = 7;

  typedef struct packed {
    logic ovf;
    logic par;
    logic tmo;
  } stat_t;

  typedef struct packed {
    logic par_irq;
    logic par_mc;
    logic tmo_irq;
    logic tmo_mc;
  } enab_t;
endpackage

// File: rtl/bus_err_rst_sync.sv
module bus_err_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bus_err_status.sv
module bus_err_status
  import bus_err_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tmo_evt_i,
  input  logic  par_evt_i,
  input  stat_t clr_i,
  output stat_t stat_o
);
  stat_t stat_q, stat_d;
  logic  any_evt, any_held, upd_en;

  always_comb begin
    any_evt    = tmo_evt_i | par_evt_i;
    any_held   = |stat_q;
    upd_en     = any_evt | (|clr_i);
    stat_d.tmo = (stat_q.tmo & ~clr_i.tmo) | tmo_evt_i;
    stat_d.par = (stat_q.par & ~clr_i.par) | par_evt_i;
    stat_d.ovf = (stat_q.ovf & ~clr_i.ovf) | (any_evt & any_held);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stat_q <= '0;
    else if (upd_en) stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt_i |=> stat_o.tmo); // R2
  AST_PAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    par_evt_i |=> stat_o.par); // R3
  AST_OVF_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ((tmo_evt_i || par_evt_i) && stat_o != '0) |=> stat_o.ovf); // R4
  AST_OVF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o == '0 && clr_i == '0) |=> !stat_o.ovf); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmo_evt_i && !par_evt_i && clr_i == '0) |=> $stable(stat_o)); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_evt_i && clr_i.tmo) |=> stat_o.tmo); // R6
endmodule

// File: rtl/bus_err_enable.sv
module bus_err_enable
  import bus_err_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [EN_W-1:0] wdata_i,
  output enab_t           en_o
);
  enab_t en_q, en_d;

  always_comb begin
    en_d = enab_t'(wdata_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= '0;
    else if (wr_i) en_q <= en_d;
  end

  assign en_o = en_q;

  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> en_o == $past(wdata_i)); // R7
  AST_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(en_o)); // R7
endmodule

// File: rtl/bus_err_route.sv
module bus_err_route
  import bus_err_pkg::*;
(
  input  stat_t                 stat_i,
  input  enab_t                 en_i,
  input  logic [MID_W-1:0]      mid_i,
  output logic [N_MASTERS-1:0]  mchk_o,
  output logic                  irq_o
);
  logic mc_any;

  always_comb begin
    mc_any = (stat_i.tmo & en_i.tmo_mc) | (stat_i.par & en_i.par_mc);
    irq_o  = (stat_i.tmo & en_i.tmo_irq) | (stat_i.par & en_i.par_irq);
  end

  for (genvar m = 0; m < N_MASTERS; m++) begin : g_master
    assign mchk_o[m] = mc_any & (mid_i == MID_W'(m));
  end
endmodule

// File: rtl/bus_err_stat.sv
module bus_err_stat
  import bus_err_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [STRB_W-1:0]    wstrb_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic                 tmo_evt_i,
  input  logic                 par_evt_i,
  input  logic [MID_W-1:0]     mid_i,
  output logic [N_MASTERS-1:0] mchk_o,
  output logic                 irq_o
);
  logic  rst_s_n;
  logic  wr_lane0, wr_stat, wr_enab;
  stat_t clr_mask, stat;
  enab_t enab;

  bus_err_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  always_comb begin
    wr_lane0     = wstrb_i[0];
    wr_stat      = wr_lane0 && (addr_i == STAT_ADDR);
    wr_enab      = wr_lane0 && (addr_i == ENAB_ADDR);
    clr_mask.tmo = wr_stat & wdata_i[TMO_BIT];
    clr_mask.par = wr_stat & wdata_i[PAR_BIT];
    clr_mask.ovf = wr_stat & wdata_i[OVF_BIT];
  end

  bus_err_status u_status (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .tmo_evt_i (tmo_evt_i),
    .par_evt_i (par_evt_i),
    .clr_i     (clr_mask),
    .stat_o    (stat)
  );

  bus_err_enable u_enable (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_i    (wr_enab),
    .wdata_i (wdata_i[EN_W-1:0]),
    .en_o    (enab)
  );

  bus_err_route u_route (
    .stat_i (stat),
    .en_i   (enab),
    .mid_i  (mid_i),
    .mchk_o (mchk_o),
    .irq_o  (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == STAT_ADDR) begin
      rdata_o[TMO_BIT] = stat.tmo;
      rdata_o[PAR_BIT] = stat.par;
      rdata_o[OVF_BIT] = stat.ovf;
    end else if (addr_i == ENAB_ADDR) begin
      rdata_o[EN_W-1:0] = enab;
    end
  end

  AST_MCHK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(mchk_o)); // R8
  AST_MCHK_TARGET: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mchk_o != '0) |-> mchk_o[mid_i]); // R8
  AST_QUIET_NO_EN: assert property (@(posedge clk) disable iff (!rst_s_n)
    (enab == '0) |-> (!irq_o && mchk_o == '0)); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_s_n |-> (stat == '0 && enab == '0)); // R1
endmodule

// File: tb/bus_err_stat_test.sv
module bus_err_stat_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [3:0]  wstrb;
  logic [31:0] rdata;
  logic        tmo_evt, par_evt;
  logic [1:0]  mid;
  logic [3:0]  mchk;
  logic        irq;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  bus_err_stat uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .wstrb_i(wstrb),
    .rdata_o(rdata), .tmo_evt_i(tmo_evt), .par_evt_i(par_evt), .mid_i(mid),
    .mchk_o(mchk), .irq_o(irq)
  );

  typedef struct packed {
    logic       tmo;
    logic       par;
    logic [3:0] strb;
    logic       adr;
    logic [7:0] wd;
    logic [1:0] mid;
    logic [7:0] xs;
    logic       xi;
    logic [3:0] xm;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,4'h0,1'b0,8'h00,2'd0,8'h01,1'b0,4'b0000}, // R2 time-out sets bit 0
    '{1'b0,1'b0,4'h1,1'b1,8'h01,2'd2,8'h01,1'b0,4'b0100}, // R8 mchk to master 2
    '{1'b0,1'b0,4'h1,1'b1,8'h03,2'd1,8'h01,1'b1,4'b0010}, // R9 irq enabled
    '{1'b0,1'b1,4'h0,1'b0,8'h00,2'd1,8'h83,1'b1,4'b0010}, // R3 R4 parity + overflow
    '{1'b0,1'b0,4'h1,1'b0,8'h01,2'd1,8'h82,1'b0,4'b0000}, // R5 clear time-out
    '{1'b0,1'b0,4'h1,1'b0,8'h00,2'd1,8'h82,1'b0,4'b0000}, // R5 zeros no effect
    '{1'b0,1'b0,4'h2,1'b0,8'h82,2'd1,8'h82,1'b0,4'b0000}, // R5 lane 0 off
    '{1'b0,1'b0,4'h1,1'b0,8'h82,2'd1,8'h00,1'b0,4'b0000}, // R5 clear par + ovf
    '{1'b1,1'b1,4'h0,1'b0,8'h00,2'd1,8'h03,1'b1,4'b0010}, // R4 both on empty: no ovf
    '{1'b1,1'b0,4'h1,1'b0,8'h01,2'd1,8'h83,1'b1,4'b0010}, // R6 set wins, ovf from old
    '{1'b0,1'b0,4'h1,1'b1,8'h0C,2'd3,8'h83,1'b1,4'b1000}, // R8 parity to master 3
    '{1'b0,1'b0,4'h1,1'b1,8'h00,2'd3,8'h83,1'b0,4'b0000}, // R9 enable removed
    '{1'b0,1'b0,4'h1,1'b0,8'hFF,2'd3,8'h00,1'b0,4'b0000}  // R5 clear all
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    tmo_evt = 1'b0; par_evt = 1'b0; wstrb = 4'h0; wdata = '0; addr = 4'd0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wstrb = 4'h1;
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(req, "rdata", rdata, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    idle();
    mid = 2'd0;
    do_reset();

    // R1 reset state
    rd_check("R1", 4'd0, 32'h0);
    rd_check("R1", 4'd1, 32'h0);
    check("R1", "irq", {31'd0, irq}, 32'h0);
    check("R1", "mchk", {28'd0, mchk}, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      tmo_evt = VECS[i].tmo;
      par_evt = VECS[i].par;
      wstrb   = VECS[i].strb;
      addr    = {3'b000, VECS[i].adr};
      wdata   = {24'd0, VECS[i].wd};
      mid     = VECS[i].mid;
      @(posedge clk);
      @(negedge clk);
      idle();
      #1;
      check("R2-table", $sformatf("v%0d status", i), rdata, {24'd0, VECS[i].xs});
      check("R9-table", $sformatf("v%0d irq", i), {31'd0, irq}, {31'd0, VECS[i].xi});
      check("R8-table", $sformatf("v%0d mchk", i), {28'd0, mchk}, {28'd0, VECS[i].xm});
    end

    // R7 enable readback, upper bits zero
    wr(4'd1, 32'hFFFF_FFFF);
    rd_check("R7", 4'd1, 32'h0000_000F);
    // R10 unmapped address and unused status bits
    wr(4'd0, 32'hFFFF_FFFF);
    rd_check("R10", 4'd5, 32'h0);
    rd_check("R10", 4'd0, 32'h0);
    // R3 parity alone with enable for parity only, master 0
    wr(4'd1, 32'h0000_0004);
    mid = 2'd0;
    @(negedge clk); par_evt = 1'b1;
    @(posedge clk); @(negedge clk); idle(); #1;
    rd_check("R3", 4'd0, 32'h0000_0002);
    check("R8", "mchk", {28'd0, mchk}, 32'h1);
    check("R9", "irq", {31'd0, irq}, 32'h0);
    // R8 master change follows mid
    mid = 2'd2; #1;
    check("R8", "mchk", {28'd0, mchk}, 32'h4);

    // R1 reset in the middle of activity
    @(negedge clk); tmo_evt = 1'b1;
    @(posedge clk); @(negedge clk); idle();
    rst_n = 1'b0; #1;
    check("R1", "mchk async", {28'd0, mchk}, 32'h0);
    do_reset();
    rd_check("R1", 4'd0, 32'h0);
    rd_check("R1", 4'd1, 32'h0);
    check("R1", "irq", {31'd0, irq}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule